// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM Core

This block is a single-clock static memory with a two-stage pipeline and a late-write protocol. On every rising clock edge it captures a command: address, synchronous select, global write enable and one write enable per byte lane. A read returns its word from a registered output stage one clock edge after the command was captured. A write supplies its data one cycle after its address. That data is sampled on the following edge and parked in a posted write buffer, together with the address and the lane mask of that write.

The posted buffer reaches the storage array only when the next accepted write comes along. That write retires the parked entry and takes its place in the same edge. Each read compares its address with the parked one. On a match, the lanes the parked write enabled are taken from the buffer and the remaining lanes come from the array. Read-after-write therefore needs no idle cycle, and the bus never turns around between a read and a following write.

An output-enable input gates the pad drive with no clock involved. A synchronous sleep input forces the drive off, makes the core ignore commands and keeps the stored data. Once sleep is released, a parameterised number of cycles must pass before commands are accepted again. The data word is made of `LANES` lanes of `LANE_W` bits each, 4 x 9 bits by default.

Top module: `late_write_sram`

## Requirements
- R1: While `rst_n` is low and after reset is released, `dq_oe_o` is 0 until the first accepted read reaches the output stage. The write buffer starts empty.
- R2: A read is accepted at a clock edge when `sel_i`=1, `wr_i`=0 and the core is awake. After the next edge, `dq_o` carries the word and `dq_oe_o`=1, provided `oe_i`=1.
- R3: For a write accepted at edge T, the data is sampled from `din_i` at edge T+1. A read accepted at edge T+1 already returns that data.
- R4: A buffered write is committed to the array only when the next accepted write occurs. From then on, reads of its address return the committed lanes.
- R5: When the read address equals the buffered address, lane k (bits 9k+8..9k) comes from the buffer if bit k of the buffered lane mask is 1, and from the array otherwise.
- R6: `wr_i`=1 makes an accepted command a write. Only lanes with `lane_we_i[k]`=1 are written. A write with an all-zero mask leaves the stored word unchanged.
- R7: A command with `sel_i`=0 performs no read or write. `dq_oe_o` is 0 after the next edge.
- R8: An accepted write drives `dq_oe_o` to 0 after the next edge.
- R9: `oe_i`=0 forces `dq_oe_o` to 0 with no clock edge, and `dq_o` keeps its value. `oe_i`=1 restores the drive.
- R10: At any edge that samples `sleep_i`=1, `dq_oe_o` goes to 0 and the command is ignored. Stored data is preserved.
- R11: After `sleep_i` returns to 0, the first `WAKE_CYCLES` edges with `sleep_i`=0 ignore commands. The next edge accepts them.
- R12: For back-to-back writes, the second write commits the first and stores its own address and lane mask. Later bypass uses the second write's mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_i | input | 1 | Synchronous select; 0 makes the cycle a deselect |
| wr_i | input | 1 | Global write enable (1 = write, 0 = read) |
| lane_we_i | input | LANES | Per-lane write enables |
| addr_i | input | ADDR_W | Word address |
| din_i | input | LANES*LANE_W | Write data, one cycle after the write's address |
| oe_i | input | 1 | Output enable, acts without a clock |
| sleep_i | input | 1 | Synchronous sleep request |
| dq_o | output | LANES*LANE_W | Registered read data |
| dq_oe_o | output | 1 | Pad drive enable (0 = high impedance) |

## Verification
On every cycle the assertions check the rules that govern the output drive. Output enable low always means no drive. A deselect or a write captured at one edge leaves the drive off two edges later. An edge that samples sleep shuts the drive off and leaves no command in the pipeline, and so does the first edge after sleep falls. Only the bench's scenarios can show the data-path behaviour, because that needs a model of the array contents. This covers the late data sampling, the deferred commit, lane-by-lane bypass after partial and back-to-back writes, masked writes that change nothing, data kept through sleep, and the exact length of the wake window.

// File: rtl/lw_pkg.sv
// Shared types for the late-write SRAM core.
// Assumes: one command per clock; the command stage emits at most one op.
package lw_pkg;
    typedef enum logic [1:0] {
        LW_IDLE  = 2'd0,
        LW_READ  = 2'd1,
        LW_WRITE = 2'd2
    } lw_op_e;
endpackage

// File: rtl/lw_cmd_stage.sv
// Command capture stage: registers address, lane mask and operation kind
// on each rising edge, and keeps the post-sleep wake counter.
// Assumes: sleep_i is synchronous to clk; WAKE_CYCLES >= 0.
module lw_cmd_stage #(
    parameter int ADDR_W      = 4,
    parameter int LANES       = 4,
    parameter int WAKE_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_i,
    input  logic                 wr_i,
    input  logic                 sleep_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [LANES-1:0]     lane_we_i,
    output lw_pkg::lw_op_e       op_q,
    output logic [ADDR_W-1:0]    addr_q,
    output logic [LANES-1:0]     mask_q
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 2);
    localparam logic [CNT_W-1:0] WAKE_LOAD = CNT_W'(WAKE_CYCLES);

    logic [CNT_W-1:0] wake_cnt;
    logic             accept;

    // A command counts only when selected, awake and past the wake window.
    assign accept = sel_i && !sleep_i && (wake_cnt == '0);

    // Wake window: reloaded while asleep, counted down once sleep drops.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake_cnt <= '0;
        else if (sleep_i)
            wake_cnt <= WAKE_LOAD;
        else if (wake_cnt != '0)
            wake_cnt <= wake_cnt - 1'b1;
    end

    // Pipeline stage 1: capture the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= lw_pkg::LW_IDLE;
            addr_q <= '0;
            mask_q <= '0;
        end else begin
            op_q <= !accept ? lw_pkg::LW_IDLE :
                    (wr_i ? lw_pkg::LW_WRITE : lw_pkg::LW_READ);
            if (accept) begin
                addr_q <= addr_i;
                mask_q <= lane_we_i;
            end
        end
    end
endmodule

// File: rtl/lw_write_buffer.sv
// Posted write buffer: holds one pending write (address, lane mask, data).
// When stage 1 holds a write, this edge samples its late data, retires
// the previous entry towards the array, and reports per-lane read hits.
// Assumes: din_i carries the data of the write now sitting in stage 1.
module lw_write_buffer #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  lw_pkg::lw_op_e            op_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [LANES-1:0]          mask_i,
    input  logic [LANES*LANE_W-1:0]   din_i,
    output logic                      commit_o,
    output logic [ADDR_W-1:0]         commit_addr_o,
    output logic [LANES-1:0]          commit_mask_o,
    output logic [LANES*LANE_W-1:0]   buf_data_o,
    output logic [LANES-1:0]          hit_mask_o
);
    logic                    valid_q;
    logic [ADDR_W-1:0]       baddr_q;
    logic [LANES-1:0]        bmask_q;
    logic [LANES*LANE_W-1:0] bdata_q;
    logic                    is_wr;
    logic                    addr_eq;

    assign is_wr         = (op_i == lw_pkg::LW_WRITE);
    assign commit_o      = is_wr && valid_q;
    assign commit_addr_o = baddr_q;
    assign commit_mask_o = bmask_q;
    assign buf_data_o    = bdata_q;
    assign addr_eq       = valid_q && (baddr_q == addr_i);

    // Per-lane bypass select for the read in stage 1.
    for (genvar k = 0; k < LANES; k++) begin : g_hit
        assign hit_mask_o[k] = addr_eq && bmask_q[k];
    end

    // Replace the parked entry with the write in stage 1 and its late data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            baddr_q <= '0;
            bmask_q <= '0;
            bdata_q <= '0;
        end else if (is_wr) begin
            valid_q <= 1'b1;
            baddr_q <= addr_i;
            bmask_q <= mask_i;
            bdata_q <= din_i;
        end
    end
endmodule

// File: rtl/lw_array.sv
// Storage array built as one bank per lane, each with a masked write port
// and a combinational read port.
// Assumes: contents are undefined until written; no reset of storage.
module lw_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         waddr_i,
    input  logic [LANES-1:0]          wmask_i,
    input  logic [LANES*LANE_W-1:0]   wdata_i,
    input  logic [ADDR_W-1:0]         raddr_i,
    output logic [LANES*LANE_W-1:0]   rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        // Lane write: only when the commit is enabled for this lane.
        always_ff @(posedge clk) begin
            if (we_i && wmask_i[k])
                bank[waddr_i] <= wdata_i[k*LANE_W +: LANE_W];
        end

        assign rdata_o[k*LANE_W +: LANE_W] = bank[raddr_i];
    end
endmodule

// File: rtl/lw_out_stage.sv
// Output stage: merges array and buffer lanes for a read in stage 1,
// registers the word and the drive flag, and gates drive with oe_i.
// Assumes: sleep_i sampled high kills the drive at that same edge.
module lw_out_stage #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  lw_pkg::lw_op_e            op_i,
    input  logic                      sleep_i,
    input  logic                      oe_i,
    input  logic [LANES*LANE_W-1:0]   arr_data_i,
    input  logic [LANES*LANE_W-1:0]   buf_data_i,
    input  logic [LANES-1:0]          hit_mask_i,
    output logic [LANES*LANE_W-1:0]   dq_o,
    output logic                      dq_oe_o
);
    logic [LANES*LANE_W-1:0] merged;
    logic                    drive_q;
    logic                    is_rd;

    assign is_rd = (op_i == lw_pkg::LW_READ);

    // Per-lane source select between buffer and array.
    for (genvar k = 0; k < LANES; k++) begin : g_mux
        assign merged[k*LANE_W +: LANE_W] = hit_mask_i[k] ?
            buf_data_i[k*LANE_W +: LANE_W] : arr_data_i[k*LANE_W +: LANE_W];
    end

    // Output register: load on read, drive only for a read outside sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
            dq_o    <= '0;
        end else begin
            drive_q <= is_rd && !sleep_i;
            if (is_rd)
                dq_o <= merged;
        end
    end

    assign dq_oe_o = oe_i && drive_q;
endmodule

// File: rtl/late_write_sram.sv
// Top of the late-write pipelined SRAM core: command stage, posted write
// buffer, lane-banked array and registered output stage.
// Assumes: one clock domain; write data follows its address by one cycle.
module late_write_sram #(
    parameter int ADDR_W      = 4,
    parameter int LANES       = 4,
    parameter int LANE_W      = 9,
    parameter int WAKE_CYCLES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_i,
    input  logic                      wr_i,
    input  logic [LANES-1:0]          lane_we_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [LANES*LANE_W-1:0]   din_i,
    input  logic                      oe_i,
    input  logic                      sleep_i,
    output logic [LANES*LANE_W-1:0]   dq_o,
    output logic                      dq_oe_o
);
    localparam int DW = LANES * LANE_W;

    lw_pkg::lw_op_e     stage_op;
    logic [ADDR_W-1:0]  stage_addr;
    logic [LANES-1:0]   stage_mask;
    logic               commit;
    logic [ADDR_W-1:0]  commit_addr;
    logic [LANES-1:0]   commit_mask;
    logic [DW-1:0]      buf_data;
    logic [LANES-1:0]   hit_mask;
    logic [DW-1:0]      arr_data;

    lw_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .WAKE_CYCLES(WAKE_CYCLES)) u_cmd (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i), .sleep_i(sleep_i),
        .addr_i(addr_i), .lane_we_i(lane_we_i),
        .op_q(stage_op), .addr_q(stage_addr), .mask_q(stage_mask)
    );

    lw_write_buffer #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .op_i(stage_op), .addr_i(stage_addr),
        .mask_i(stage_mask), .din_i(din_i),
        .commit_o(commit), .commit_addr_o(commit_addr), .commit_mask_o(commit_mask),
        .buf_data_o(buf_data), .hit_mask_o(hit_mask)
    );

    lw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .we_i(commit), .waddr_i(commit_addr), .wmask_i(commit_mask),
        .wdata_i(buf_data), .raddr_i(stage_addr), .rdata_o(arr_data)
    );

    lw_out_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
        .clk(clk), .rst_n(rst_n), .op_i(stage_op), .sleep_i(sleep_i), .oe_i(oe_i),
        .arr_data_i(arr_data), .buf_data_i(buf_data), .hit_mask_i(hit_mask),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o)
    );
endmodule

// File: rtl/lw_sram_checker.sv
// Checker for late_write_sram: output-drive and sleep rules at every edge.
// Assumes: attached by bind; op_q is the command-stage operation.
module lw_sram_checker #(
    parameter int WAKE_CYCLES = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sel_i,
    input logic           wr_i,
    input logic           sleep_i,
    input logic           oe_i,
    input logic           dq_oe_o,
    input lw_pkg::lw_op_e op_q
);
    // R9: output enable low means no drive
    assert_oe_gates_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_i |-> !dq_oe_o);

    // R7: a deselect leaves the pads undriven two edges later
    assert_deselect_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> ##1 !dq_oe_o);

    // R8: a write command leaves the pads undriven two edges later
    assert_write_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && wr_i) |=> ##1 !dq_oe_o);

    // R10: sleep shuts the drive off at the sampling edge
    assert_sleep_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> !dq_oe_o);

    // R10: a command during sleep never enters the pipeline
    assert_sleep_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (op_q == lw_pkg::LW_IDLE));

    if (WAKE_CYCLES > 0) begin : g_wake
        // R11: the first edge after sleep falls is still inside the wake window
        assert_wake_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(sleep_i) && $past(rst_n)) |=> (op_q == lw_pkg::LW_IDLE));
    end
endmodule

bind late_write_sram lw_sram_checker #(.WAKE_CYCLES(WAKE_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i), .sleep_i(sleep_i),
    .oe_i(oe_i), .dq_oe_o(dq_oe_o), .op_q(stage_op)
);

// File: tb/late_write_sram_test.sv
module late_write_sram_test;
    localparam int AW = 4;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam int WAKE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_i = 1'b0, wr_i = 1'b0, oe_i = 1'b1, sleep_i = 1'b0;
    logic [NL-1:0] lane_we_i = '0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] din_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe_o;

    late_write_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .WAKE_CYCLES(WAKE)) uut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i), .lane_we_i(lane_we_i),
        .addr_i(addr_i), .din_i(din_i), .oe_i(oe_i), .sleep_i(sleep_i),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    // Spec model: array, one posted entry, wake counter
    logic [DW-1:0] marr [1<<AW];
    logic          bvalid = 1'b0;
    logic [AW-1:0] baddr = '0;
    logic [NL-1:0] bmask = '0;
    logic [DW-1:0] bdata = '0;
    logic [DW-1:0] carry = '0;
    int            bwake = 0;

    // Scoreboard queues
    int            due_q[$];
    bit            rd_q[$];
    logic [DW-1:0] val_q[$];
    string         tag_q[$];

    function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
        logic [DW-1:0] r;
        r = marr[a];
        for (int k = 0; k < NL; k++)
            if (bvalid && baddr == a && bmask[k]) r[k*LW +: LW] = bdata[k*LW +: LW];
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return {9'(a + salt + 9'h1c0), 9'(a + salt + 9'h100),
                9'(a + salt + 9'h080), 9'(a + salt + 9'h040)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one command per cycle; pushes the expected output
    task automatic step(input bit s, input bit w, input logic [NL-1:0] m,
                        input int a, input logic [DW-1:0] d, input bit slp,
                        input string tag);
        bit acc;
        @(negedge clk);
        sel_i = s; wr_i = w; lane_we_i = m; addr_i = AW'(a); sleep_i = slp;
        din_i = carry;
        carry = '0;
        acc = s && !slp && (bwake == 0);
        if (slp) bwake = WAKE; else if (bwake > 0) bwake--;
        due_q.push_back(cyc + 2);
        rd_q.push_back(acc && !w);
        val_q.push_back((acc && !w) ? model_read(AW'(a)) : '0);
        tag_q.push_back(tag);
        if (acc && w) begin
            if (bvalid)
                for (int k = 0; k < NL; k++)
                    if (bmask[k]) marr[baddr][k*LW +: LW] = bdata[k*LW +: LW];
            bvalid = 1'b1; baddr = AW'(a); bmask = m; bdata = d;
            carry = d;
        end
    endtask

    task automatic rd(input int a, input string tag);
        step(1, 0, '0, a, '0, 0, tag);
    endtask
    task automatic wrt(input int a, input logic [NL-1:0] m, input logic [DW-1:0] d,
                       input string tag);
        step(1, 1, m, a, d, 0, tag);
    endtask
    task automatic idle(input string tag);
        step(0, 0, '0, 0, '0, 0, tag);
    endtask

    // Monitor: compares each due expectation on the falling edge
    always @(negedge clk) begin
        if (due_q.size() > 0 && due_q[0] == cyc) begin
            int    d;
            bit    r;
            logic [DW-1:0] v;
            string t;
            d = due_q.pop_front(); r = rd_q.pop_front();
            v = val_q.pop_front(); t = tag_q.pop_front();
            checks++;
            if (r && (dq_oe_o !== 1'b1 || dq_o !== v)) begin
                bad++;
                $display("FAIL %s read: actual oe=%b data=%h expected oe=1 data=%h",
                         t, dq_oe_o, dq_o, v);
            end else if (!r && dq_oe_o !== 1'b0) begin
                bad++;
                $display("FAIL %s idle: actual oe=%b expected oe=0 (due %0d)",
                         t, dq_oe_o, d);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        for (int i = 0; i < (1 << AW); i++) marr[i] = '0;
        repeat (3) @(negedge clk);
        chk(dq_oe_o == 1'b0, "R1 drive off in reset", {35'd0, dq_oe_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dq_oe_o == 1'b0, "R1 drive off after reset", {35'd0, dq_oe_o}, '0);

        // R8: fill the array with full-mask writes, pads stay undriven
        for (int a = 0; a < (1 << AW); a++) wrt(a, 4'hf, pat(a, 0), "R8 fill write");
        // R3: read right after the last write sees its late data
        rd(15, "R3 read after write");
        // R4: earlier writes committed by later writes
        rd(3, "R4 committed word");
        rd(0, "R2 read addr 0");
        rd(14, "R2 read addr 14");

        // R5: partial write, bypass lanes 0 and 2 from buffer
        wrt(5, 4'b0101, pat(5, 7), "R8 partial write");
        rd(5, "R5 lane bypass");
        rd(5, "R5 lane bypass again");
        // R4/R6: commit it with another write, then read merged array word
        wrt(6, 4'b1000, pat(6, 3), "R6 single-lane write");
        rd(5, "R4 merged after commit");
        rd(6, "R6 single lane via bypass");

        // R12: back-to-back writes with different masks
        wrt(7, 4'b0011, pat(7, 9), "R12 first write");
        wrt(8, 4'b1100, pat(8, 11), "R12 second write");
        rd(8, "R12 bypass with new mask");
        rd(7, "R12 first write committed");

        // R6: global write with empty mask changes nothing
        wrt(9, 4'b0000, pat(9, 5), "R6 empty mask write");
        rd(9, "R6 empty mask read");
        wrt(10, 4'b0000, '0, "R6 flush empty");
        rd(9, "R6 empty mask after commit");

        // R7: deselect cycles, even with write asserted
        step(0, 1, 4'hf, 2, pat(2, 1), 0, "R7 deselect with write");
        idle("R7 deselect");
        rd(2, "R7 deselect wrote nothing");

        // R9: asynchronous output enable
        rd(4, "R9 read before oe test");
        idle("R9 idle");
        @(negedge clk);
        #2;
        held = dq_o;
        chk(dq_oe_o == 1'b1, "R9 drive on with oe", {35'd0, dq_oe_o}, 36'd1);
        oe_i = 1'b0;
        #1;
        chk(dq_oe_o == 1'b0, "R9 oe low forces hi-z", {35'd0, dq_oe_o}, '0);
        chk(dq_o == held, "R9 data held under oe low", dq_o, held);
        oe_i = 1'b1;
        #1;
        chk(dq_oe_o == 1'b1, "R9 oe restored", {35'd0, dq_oe_o}, 36'd1);

        // R10: sleep ignores reads and writes, contents kept
        idle("R10 pre-sleep idle");
        step(1, 0, '0, 4, '0, 1, "R10 read in sleep");
        step(1, 1, 4'hf, 11, pat(11, 2), 1, "R10 write in sleep");
        step(1, 0, '0, 3, '0, 1, "R10 read in sleep 2");
        // R11: wake window ignores WAKE commands
        for (int i = 0; i < WAKE; i++) wrt(11, 4'hf, pat(11, 4), "R11 write in wake window");
        rd(11, "R11 first accepted read, old data");
        rd(3, "R10 contents kept");
        wrt(12, 4'b0010, pat(12, 6), "R11 write after wake");
        rd(12, "R11 write accepted after wake");

        repeat (4) idle("drain");
        while (due_q.size() > 0) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule